// File: doc/BRIEF.md
# Gated-Count Result Recovery for a Dual-Slope Converter

This block recovers the binary reading of a dual-slope converter that only drives a display and offers no data bus. The converter has a status line. The line is high while the converter integrates the input and then de-integrates the reference, and it is low during auto-zero. The block counts rising edges of the converter's raw oscillator clock while that line is high. When the line falls it turns the count into a signed reading.

The converter's internal counting clock runs at one quarter of its oscillator frequency. The integrate phase always takes a fixed 1000 internal counts. The reading is therefore the gated count divided by four, with the fraction dropped, minus 1000. A separate polarity line gives the sign. The resulting magnitude matches the value the converter shows on its own display, from 0 to 1999.

All three converter-side inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer before any edge is detected. A reading is delivered with a one-cycle strobe and held until the next one. A sticky flag marks windows that were too short or that overflowed the counter.

Top module: `gated_count_capture`

## Requirements
- R1: After reset, result_o is 0, valid_o is 0 and error_o is 0.
- R2: The window counter advances once per rising edge of conv_clk_i seen while the synchronized status is high. Edges of conv_clk_i while status is low have no effect on the next reading.
- R3: A rising edge of status clears the counter, so each reading depends only on the edges counted in its own high window.
- R4: A falling edge of status_i causes valid_o to be high for exactly one system clock. valid_o rises on the third rising system clock edge after status_i falls: two synchronizer stages plus one output register.
- R5: For a count N with 4000 <= N < 2^CNT_W, the magnitude of the reading is floor(N/4) - 1000. The two low bits of N are discarded.
- R6: polarity_i sampled at capture selects the sign. A value of 1 gives a positive result_o and a value of 0 gives the two's-complement negative. A change of polarity_i after capture does not alter the held reading.
- R7: result_o keeps its value in every cycle in which valid_o is low.
- R8: A window count below 4000 sets error_o. The reading delivered with valid_o is then 0.
- R9: A window whose count passes 2^CNT_W - 1 sets error_o. The reading delivered with valid_o is then 0.
- R10: Once set, error_o stays high until reset. Later good windows still update result_o and pulse valid_o.
- R11: The counts 4000 and 11999 give magnitudes 0 and 1999. These are the ends of the converter's displayed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_clk_i | input | 1 | Raw oscillator clock of the converter, sampled as data |
| status_i | input | 1 | Converter phase status: high during integrate and de-integrate |
| polarity_i | input | 1 | Converter sign line: 1 means a positive input |
| result_o | output | CNT_W | Signed two's-complement reading |
| valid_o | output | 1 | One-cycle strobe when a new reading is presented |
| error_o | output | 1 | Sticky flag for a short or overflowed window |

## Verification
The assertions check the following on every cycle:
- the strobe lasts a single cycle and follows each synchronized status fall;
- the counter clears on a status rise and holds while status is low;
- the reading stays frozen between strobes;
- the error flag never drops;
- a reading flagged as bad is zero.

The arithmetic can only be shown by the bench's windows of known edge count, swept across the range edges, the discarded low bits and both signs. These scenarios also cover the exact strobe latency, a polarity change after capture, an overflowing window, and recovery after reset.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

  localparam int GCC_CNT_W_DEF  = 16;
  localparam int GCC_SHIFT_DEF  = 2;
  localparam int GCC_OFFSET_DEF = 1000;
  localparam int GCC_SYNC_DEF   = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } gcc_edge_t;

endpackage

// File: rtl/gcc_sync.sv
module gcc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/gcc_edge.sv
module gcc_edge
  import gcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  output gcc_edge_t ev
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl;
    end
  end

  always_comb begin
    ev.rise = lvl & ~prev_q;
    ev.fall = ~lvl & prev_q;
  end

endmodule

// File: rtl/gcc_counter.sv
module gcc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc) begin
      cnt_d = sum[CNT_W-1:0];
      ovf_d = ovf_q | sum[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

endmodule

// File: rtl/gcc_scale.sv
module gcc_scale #(
  parameter int CNT_W  = 16,
  parameter int SHIFT  = 2,
  parameter int OFFSET = 1000
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovf,
  input  logic             positive,
  output logic [CNT_W-1:0] value,
  output logic             bad
);

  localparam logic [CNT_W-1:0] OFS_V   = CNT_W'(OFFSET);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(OFFSET << SHIFT);

  logic [CNT_W-1:0] quot;
  logic [CNT_W-1:0] mag;

  always_comb begin
    quot  = cnt >> SHIFT;
    mag   = quot - OFS_V;
    bad   = ovf | (cnt < MIN_CNT);
    if (bad) begin
      value = '0;
    end else if (positive) begin
      value = mag;
    end else begin
      value = (~mag) + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/gated_count_capture.sv
module gated_count_capture
  import gcc_pkg::*;
#(
  parameter int CNT_W       = GCC_CNT_W_DEF,
  parameter int SHIFT       = GCC_SHIFT_DEF,
  parameter int OFFSET      = GCC_OFFSET_DEF,
  parameter int SYNC_STAGES = GCC_SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_clk_i,
  input  logic             status_i,
  input  logic             polarity_i,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             error_o
);

  localparam int N_SYNC = 3;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_q = rst_pipe_q[1];

  // synchronized converter-side lines
  logic [N_SYNC-1:0] raw_in, sync_out;
  logic              status_s, pol_s, cclk_s;

  assign raw_in = {polarity_i, status_i, conv_clk_i};

  gcc_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n_q),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign cclk_s   = sync_out[0];
  assign status_s = sync_out[1];
  assign pol_s    = sync_out[2];

  gcc_edge_t st_ev, ck_ev;

  gcc_edge i_st_edge (
    .clk   (clk),
    .rst_n (rst_n_q),
    .lvl   (status_s),
    .ev    (st_ev)
  );

  gcc_edge i_ck_edge (
    .clk   (clk),
    .rst_n (rst_n_q),
    .lvl   (cclk_s),
    .ev    (ck_ev)
  );

  // gated window counter
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             cnt_inc;

  assign cnt_inc = status_s & ck_ev.rise;

  gcc_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n_q),
    .clr   (st_ev.rise),
    .inc   (cnt_inc),
    .cnt   (cnt_q),
    .ovf   (ovf_q)
  );

  // scaling and offset removal
  logic [CNT_W-1:0] value;
  logic             bad;

  gcc_scale #(.CNT_W(CNT_W), .SHIFT(SHIFT), .OFFSET(OFFSET)) i_scale (
    .cnt      (cnt_q),
    .ovf      (ovf_q),
    .positive (pol_s),
    .value    (value),
    .bad      (bad)
  );

  // capture registers
  logic [CNT_W-1:0] result_q, result_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic             cap_en;

  assign cap_en = st_ev.fall;

  always_comb begin
    result_d = result_q;
    err_d    = err_q;
    valid_d  = cap_en;
    if (cap_en) begin
      result_d = value;
      err_d    = err_q | bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
  assign error_o  = err_q;

endmodule

// File: rtl/gcc_checker.sv
module gcc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             status_s,
  input logic [CNT_W-1:0] cnt,
  input logic             valid,
  input logic             err,
  input logic [CNT_W-1:0] result
);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R4
  capture_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_s) |=> valid);

  // R3
  clear_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_s) |=> (cnt == '0));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_s |=> $stable(cnt));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result));

  // R10
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8
  error_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $rose(err)) |-> (result == '0));

endmodule

bind gated_count_capture gcc_checker #(.CNT_W(CNT_W)) i_gcc_checker (
  .clk      (clk),
  .rst_n    (rst_n_q),
  .status_s (status_s),
  .cnt      (cnt_q),
  .valid    (valid_o),
  .err      (error_o),
  .result   (result_o)
);

// File: tb/test_gated_count_capture.sv
module test_gated_count_capture;

  localparam int CNT_W = 14;

  logic             clk;
  logic             rst_n;
  logic             conv_clk_i;
  logic             status_i;
  logic             polarity_i;
  logic [CNT_W-1:0] result_o;
  logic             valid_o;
  logic             error_o;

  int checks;
  int errors;
  bit err_exp;

  gated_count_capture #(.CNT_W(CNT_W)) i_gated_count_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_clk_i (conv_clk_i),
    .status_i   (status_i),
    .polarity_i (polarity_i),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .error_o    (error_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sres();
    return int'($signed(result_o));
  endfunction

  // One status-high window with exactly n conv-clock rising edges.
  task automatic window(input int n, input bit pol, input string req);
    int exp_res;
    bit bad;
    int held;
    bad = (n < 4000) || (n >= (1 << CNT_W));
    if (bad) exp_res = 0;
    else     exp_res = pol ? (n / 4 - 1000) : -(n / 4 - 1000);
    if (bad) err_exp = 1'b1;

    @(negedge clk);
    conv_clk_i = 1'b0;
    status_i   = 1'b1;
    polarity_i = pol;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      conv_clk_i = 1'b1;
      @(negedge clk);
      conv_clk_i = 1'b0;
      @(negedge clk);
    end
    status_i = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R4 early1", int'(valid_o), 0);
    @(negedge clk);
    check(valid_o == 1'b0, "R4 early2", int'(valid_o), 0);
    @(negedge clk);
    check(valid_o == 1'b1, "R4 strobe", int'(valid_o), 1);
    check(sres() == exp_res, req, sres(), exp_res);
    check(error_o == err_exp, "R8 R9 R10 error", int'(error_o), int'(err_exp));
    held = sres();
    @(negedge clk);
    check(valid_o == 1'b0, "R4 one cycle", int'(valid_o), 0);

    // auto-zero gap: conv clock keeps running, polarity flips
    polarity_i = ~pol;
    for (int i = 0; i < 24; i++) begin
      conv_clk_i = 1'b1;
      @(negedge clk);
      conv_clk_i = 1'b0;
      @(negedge clk);
    end
    check(valid_o == 1'b0, "R7 no strobe in gap", int'(valid_o), 0);
    check(sres() == held, "R7 R6 held after gap", sres(), held);
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    err_exp    = 1'b0;
    rst_n      = 1'b0;
    conv_clk_i = 1'b0;
    status_i   = 1'b0;
    polarity_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(result_o == '0, "R1 result", int'(result_o), 0);
    check(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    check(error_o == 1'b0, "R1 error", int'(error_o), 0);

    // conv clock edges while status is low before any window
    for (int i = 0; i < 16; i++) begin
      conv_clk_i = 1'b1;
      @(negedge clk);
      conv_clk_i = 1'b0;
      @(negedge clk);
    end

    window(4000,  1'b1, "R11 R5 zero reading");
    window(4003,  1'b0, "R3 R5 low bits dropped, negative zero");
    window(4004,  1'b0, "R2 R6 negative one");
    window(7996,  1'b1, "R5 R6 mid scale positive");
    window(11999, 1'b0, "R11 full scale negative");
    window(3999,  1'b1, "R8 short window");
    window(4004,  1'b1, "R10 update after error");

    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    err_exp = 1'b0;
    repeat (4) @(negedge clk);
    check(error_o == 1'b0, "R1 R10 error cleared by reset", int'(error_o), 0);
    check(result_o == '0, "R1 result after reset", int'(result_o), 0);

    window(16390, 1'b1, "R9 overflow window");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule